// File: doc/BRIEF.md
# Multibank SDRAM Open-Page Scheduler

This block turns single-word memory requests into SDRAM commands. Four external memory selects each carry one SDRAM device with four internal banks. For every device the block remembers which row is open. Each request is classified against that record as a row hit, a closed bank or a row conflict, and the block emits the shortest legal command sequence for it. That sequence is made from ACTIVATE, PRECHARGE, READ and WRITE commands.

Selects 0 and 1 are multibank: each of their four banks can hold its own open row, and a conflict closes only the bank that conflicts. Selects 2 and 3 are single-page: each holds one open row in total, and opening any other row first closes that row. The whole system therefore holds at most ten open rows.

Requests arrive on a valid/ready handshake and are handled one at a time. The command bus carries an opcode, a select, a bank and a row or column value. An access-done pulse marks the cycle of the READ or WRITE. Two inputs set the activate-to-access delay (tRCD) and the precharge-to-activate delay (tRP) as cycle counts. These inputs are read while a request is in progress and may only be changed while the block is idle.

Top module: `sdram_page_sched`

## Requirements
- R1: After reset every row is closed, `req_ready` is high and `cmd_op` is NOP, so the first access to any bank starts with ACTIVATE.
- R2: A request to a bank with no open row issues ACTIVATE, carrying the row, in the cycle after acceptance. The READ or WRITE follows exactly `trcd_cycles` cycles later and carries the column. `acc_done` is high only in that access cycle.
- R3: A request whose row is already open in its bank issues READ or WRITE in the cycle after acceptance, with no PRECHARGE or ACTIVATE before it.
- R4: On selects 0 and 1, activating a bank leaves the open rows of the other three banks untouched, so later requests to those rows are hits.
- R5: On selects 0 and 1, a request to a different row in an open bank issues PRECHARGE to that bank only in the cycle after acceptance. ACTIVATE follows exactly `trp_cycles` later and the access `trcd_cycles` after that.
- R6: On selects 2 and 3, only one row is open. A request to any other row, in any bank, first precharges the bank that holds the open row, then follows the timing of R5.
- R7: Any two ACTIVATE commands are at least `trcd_cycles` + 1 cycles apart (tRRD).
- R8: Address fields are fixed as follows: bank = `req_addr[18:17]`, row = `req_addr[16:8]`, column = `req_addr[7:0]`. Opcodes on `cmd_op` are NOP=0, ACTIVATE=1, PRECHARGE=2, READ=3 and WRITE=4. `cmd_addr` holds the row for ACTIVATE, the zero-extended column for READ/WRITE, and 0 for PRECHARGE.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the access cycle, and no command is issued while it is high.
- R10: No more than ten rows are open at once: four on each multibank select and one on each single-page select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trcd_cycles | input | 4 | Activate-to-access delay in cycles, at least 1 |
| trp_cycles | input | 4 | Precharge-to-activate delay in cycles, at least 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_sel | input | 2 | External memory select |
| req_addr | input | 19 | Word address (bank, row, column) |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_op | output | 3 | Command opcode |
| cmd_sel | output | 2 | Select the command targets |
| cmd_bank | output | 2 | Internal bank the command targets |
| cmd_addr | output | 9 | Row or column value |
| acc_done | output | 1 | Pulse in the READ/WRITE cycle |

## Verification
The assertions assume that `trcd_cycles` and `trp_cycles` are never zero and change only while `req_ready` is high. Under those assumptions the timing checks compare the gap since the last ACTIVATE or PRECHARGE with the exact programmed count. The bench changes both delays only after waiting for an idle cycle and uses settings from 1 to 5. Its random phases draw rows from a small set so that hits, conflicts and closed banks all occur often on both kinds of select.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_PRE = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4
  } sps_op_e;

  localparam int BANKS  = 4;
  localparam int BANK_W = 2;

  function automatic logic is_access(input sps_op_e op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction

endpackage

// File: rtl/sps_act_timer.sv
module sps_act_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic [CNT_W-1:0] trcd,
  output logic [CNT_W:0]   since_act,
  output logic             rrd_ok
);

  // Cycles elapsed since the last ACTIVATE, saturating at all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_act <= '1;
    else if (act_fire)         since_act <= (CNT_W+1)'(1);
    else if (since_act != '1)  since_act <= since_act + 1'b1;
  end

  // The ACTIVATE-to-ACTIVATE spacing is the activate-to-access delay plus one.
  function automatic logic [CNT_W:0] rrd_of(input logic [CNT_W-1:0] d);
    return {1'b0, d} + (CNT_W+1)'(1);
  endfunction

  assign rrd_ok = (since_act >= rrd_of(trcd));

endmodule

// File: rtl/sps_row_table.sv
module sps_row_table
  import sps_pkg::*;
#(
  parameter int NUM_SEL   = 4,
  parameter int MULTI_SEL = 2,
  parameter int SEL_W     = 2,
  parameter int ROW_W     = 9,
  parameter int TOT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  lk_sel,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_hit,
  output logic              lk_conf,
  output logic [BANK_W-1:0] lk_victim,
  input  logic              act_en,
  input  logic              pre_en,
  input  logic [SEL_W-1:0]  up_sel,
  input  logic [BANK_W-1:0] up_bank,
  input  logic [ROW_W-1:0]  up_row,
  output logic [TOT_W-1:0]  open_total
);

  localparam int OPEN_MAX = MULTI_SEL * BANKS + (NUM_SEL - MULTI_SEL);

  logic [NUM_SEL-1:0] s_hit, s_conf;
  logic [BANK_W-1:0]  s_vic [NUM_SEL];
  logic [2:0]         s_cnt [NUM_SEL];

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    localparam logic [SEL_W-1:0] SID = SEL_W'(s);
    if (s < MULTI_SEL) begin : g_multi
      // One open row per internal bank.
      logic [BANKS-1:0]            vld_q;
      logic [BANKS-1:0][ROW_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= '0;
          row_q <= '0;
        end else begin
          if (act_en && up_sel == SID) begin
            vld_q[up_bank] <= 1'b1;
            row_q[up_bank] <= up_row;
          end
          if (pre_en && up_sel == SID) vld_q[up_bank] <= 1'b0;
        end
      end
      assign s_hit[s]  = vld_q[lk_bank] && (row_q[lk_bank] == lk_row);
      assign s_conf[s] = vld_q[lk_bank] && (row_q[lk_bank] != lk_row);
      assign s_vic[s]  = lk_bank;
      assign s_cnt[s]  = 3'($countones(vld_q));

      assert_act_closed_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && up_sel == SID) |-> !vld_q[up_bank]);
    end else begin : g_single
      // A single open row for the whole device.
      logic              vld_q;
      logic [BANK_W-1:0] bank_q;
      logic [ROW_W-1:0]  row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          bank_q <= '0;
          row_q  <= '0;
        end else begin
          if (act_en && up_sel == SID) begin
            vld_q  <= 1'b1;
            bank_q <= up_bank;
            row_q  <= up_row;
          end
          if (pre_en && up_sel == SID) vld_q <= 1'b0;
        end
      end
      assign s_hit[s]  = vld_q && (bank_q == lk_bank) && (row_q == lk_row);
      assign s_conf[s] = vld_q && !((bank_q == lk_bank) && (row_q == lk_row));
      assign s_vic[s]  = bank_q;
      assign s_cnt[s]  = {2'b00, vld_q};

      assert_single_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && up_sel == SID) |-> !vld_q);
    end
  end

  assign lk_hit    = s_hit[lk_sel];
  assign lk_conf   = s_conf[lk_sel];
  assign lk_victim = s_vic[lk_sel];

  always_comb begin
    open_total = '0;
    for (int i = 0; i < NUM_SEL; i++) open_total = open_total + TOT_W'(s_cnt[i]);
  end

  assert_open_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(open_total) <= OPEN_MAX);

endmodule

// File: rtl/sdram_page_sched.sv
module sdram_page_sched
  import sps_pkg::*;
#(
  parameter int NUM_SEL   = 4,
  parameter int MULTI_SEL = 2,
  parameter int COL_W     = 8,
  parameter int ROW_W     = 9,
  parameter int CNT_W     = 4,
  parameter int SEL_W     = $clog2(NUM_SEL),
  parameter int ADDR_W    = COL_W + ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  trcd_cycles,
  input  logic [CNT_W-1:0]  trp_cycles,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic [2:0]        cmd_op,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic              acc_done
);

  localparam int BANK_LSB = COL_W + ROW_W;
  localparam int TOT_W    = $clog2(NUM_SEL * BANKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_WRP, ST_WRCD} st_e;

  function automatic logic [CNT_W-1:0] less_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  st_e               st_q, st_d;
  logic [CNT_W-1:0]  tmr_q, tmr_d;
  logic [SEL_W-1:0]  sel_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q, did_act_q, pre_pend_q;
  logic [CNT_W:0]    since_pre;

  // Internal events brought out for the checks.
  sps_op_e           op;
  logic              act_en, pre_en, go_act, go_rw, take;
  logic              lk_hit, lk_conf, rrd_ok;
  logic [BANK_W-1:0] lk_victim;
  logic [CNT_W:0]    since_act;
  logic [TOT_W-1:0]  open_total;

  assign take = req_valid && req_ready;

  sps_row_table #(
    .NUM_SEL(NUM_SEL), .MULTI_SEL(MULTI_SEL), .SEL_W(SEL_W),
    .ROW_W(ROW_W), .TOT_W(TOT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .lk_sel(sel_q), .lk_bank(bank_q), .lk_row(row_q),
    .lk_hit(lk_hit), .lk_conf(lk_conf), .lk_victim(lk_victim),
    .act_en(act_en), .pre_en(pre_en),
    .up_sel(sel_q), .up_bank(pre_en ? lk_victim : bank_q), .up_row(row_q),
    .open_total(open_total)
  );

  sps_act_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .act_fire(act_en), .trcd(trcd_cycles),
    .since_act(since_act), .rrd_ok(rrd_ok)
  );

  always_comb begin
    st_d     = st_q;
    tmr_d    = tmr_q;
    op       = OP_NOP;
    cmd_bank = bank_q;
    cmd_addr = '0;
    act_en   = 1'b0;
    pre_en   = 1'b0;
    go_act   = 1'b0;
    go_rw    = 1'b0;
    acc_done = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_EVAL;
      ST_EVAL: begin
        if (lk_hit) go_rw = 1'b1;
        else if (lk_conf) begin
          op       = OP_PRE;
          pre_en   = 1'b1;
          cmd_bank = lk_victim;
          tmr_d    = less_one(trp_cycles);
          st_d     = ST_WRP;
        end else go_act = 1'b1;
      end
      ST_WRP:  if (tmr_q != '0) tmr_d = tmr_q - 1'b1; else go_act = 1'b1;
      ST_WRCD: if (tmr_q != '0) tmr_d = tmr_q - 1'b1; else go_rw = 1'b1;
      default: st_d = ST_IDLE;
    endcase
    if (go_act) begin
      if (rrd_ok) begin
        op       = OP_ACT;
        act_en   = 1'b1;
        cmd_addr = row_q;
        tmr_d    = less_one(trcd_cycles);
        st_d     = ST_WRCD;
      end else begin
        tmr_d = '0;
        st_d  = ST_WRP;
      end
    end
    if (go_rw) begin
      op       = wr_q ? OP_WR : OP_RD;
      cmd_addr = ROW_W'(col_q);
      acc_done = 1'b1;
      st_d     = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      tmr_q      <= '0;
      sel_q      <= '0;
      bank_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      did_act_q  <= 1'b0;
      pre_pend_q <= 1'b0;
      since_pre  <= '1;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      if (take) begin
        sel_q     <= req_sel;
        bank_q    <= req_addr[BANK_LSB +: BANK_W];
        row_q     <= req_addr[COL_W +: ROW_W];
        col_q     <= req_addr[COL_W-1:0];
        wr_q      <= req_write;
        did_act_q <= 1'b0;
      end else if (act_en) did_act_q <= 1'b1;
      if (pre_en)      pre_pend_q <= 1'b1;
      else if (act_en) pre_pend_q <= 1'b0;
      if (pre_en)                since_pre <= (CNT_W+1)'(1);
      else if (since_pre != '1)  since_pre <= since_pre + 1'b1;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign cmd_op    = op;
  assign cmd_sel   = sel_q;

  assert_rcd_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_access(op) && did_act_q) |-> since_act == {1'b0, trcd_cycles});
  assert_access_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_access(op) |-> lk_hit);
  assert_pre_on_conflict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PRE) |-> lk_conf);
  assert_rp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ACT && pre_pend_q) |-> since_pre == {1'b0, trp_cycles});
  assert_act_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ACT) |-> since_act > {1'b0, trcd_cycles});
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (op == OP_NOP && !acc_done));

endmodule

// File: tb/sdram_page_sched_tb.sv
module sdram_page_sched_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] trcd_cycles = 4'd2, trp_cycles = 4'd3;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_sel = '0;
  logic [18:0] req_addr = '0;
  logic       req_ready, acc_done;
  logic [2:0] cmd_op;
  logic [1:0] cmd_sel, cmd_bank;
  logic [8:0] cmd_addr;

  always #2 clk = ~clk; // 250 MHz

  sdram_page_sched u_dut (
    .clk(clk), .rst_n(rst_n), .trcd_cycles(trcd_cycles), .trp_cycles(trp_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_addr(req_addr), .req_write(req_write), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .acc_done(acc_done)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  bit mon_en = 0, ended = 0;
  int exp_op [int];
  int exp_sel [int];
  int exp_bank [int];
  int exp_addr [int];
  string exp_tag [int];
  int busy_from = -1, busy_until = -1;
  int last_act = -1000;
  int trcd = 2, trp = 3;
  bit mvld [4][4];
  int mrow [4][4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Per-cycle comparison against the behavioural expectation.
  always @(negedge clk) begin
    if (mon_en) begin
      int    e_op;
      string tg;
      bit    busy;
      e_op = exp_op.exists(cyc) ? exp_op[cyc] : 0;
      tg   = exp_tag.exists(cyc) ? exp_tag[cyc] : "R9";
      busy = (cyc >= busy_from) && (cyc < busy_until);
      chk(int'(cmd_op) == e_op, tg, "cmd_op", cmd_op, e_op);
      chk(req_ready == !busy, "R9", "req_ready", req_ready, !busy);
      chk(acc_done == (e_op == 3 || e_op == 4), "R2", "acc_done", acc_done, (e_op == 3 || e_op == 4));
      if (e_op != 0) begin
        chk(int'(cmd_sel) == exp_sel[cyc], "R8", "cmd_sel", cmd_sel, exp_sel[cyc]);
        chk(int'(cmd_bank) == exp_bank[cyc], "R8", "cmd_bank", cmd_bank, exp_bank[cyc]);
        chk(int'(cmd_addr) == exp_addr[cyc], "R8", "cmd_addr", cmd_addr, exp_addr[cyc]);
      end
      if (cmd_op == 3'd1) begin
        chk(cyc - last_act >= trcd + 1, "R7", "act gap", cyc - last_act, trcd + 1);
        last_act = cyc;
      end
    end
  end

  task automatic put(input int t, input int op, input int s, input int b, input int a, input string tg);
    exp_op[t] = op; exp_sel[t] = s; exp_bank[t] = b; exp_addr[t] = a; exp_tag[t] = tg;
  endtask

  task automatic do_req(input int s, input int b, input int r, input int c, input bit w, input string tg);
    int  n, t, ob;
    bit  hit, conf;
    string tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n = cyc + 1;
    hit = 0; conf = 0; ob = -1;
    if (s < 2) begin
      if (mvld[s][b]) begin ob = b; hit = (mrow[s][b] == r); conf = !hit; end
    end else begin
      for (int k = 0; k < 4; k++) if (mvld[s][k]) ob = k;
      if (ob >= 0) begin hit = (ob == b) && (mrow[s][ob] == r); conf = !hit; end
    end
    t = n;
    if (hit) begin
      tag = (tg != "") ? tg : "R3";
    end else begin
      tag = (tg != "") ? tg : (s >= 2 ? "R6" : (conf ? "R5" : "R2"));
      if (conf) begin
        put(t, 2, s, ob, 0, tag);
        mvld[s][ob] = 0;
        t += trp;
      end
      put(t, 1, s, b, r, tag);
      mvld[s][b] = 1; mrow[s][b] = r;
      t += trcd;
    end
    put(t, w ? 4 : 3, s, b, c, tag);
    busy_from = n; busy_until = t + 1;
    req_valid = 1'b1; req_sel = 2'(s); req_write = w;
    req_addr = {2'(b), 9'(r), 8'(c)};
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_timing(input int rcd, input int rp);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    trcd = rcd; trp = rp;
    trcd_cycles = 4'(rcd); trp_cycles = 4'(rp);
  endtask

  task automatic rand_phase(input int count);
    for (int i = 0; i < count; i++)
      do_req($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(2, 0),
             $urandom_range(255, 0), 1'($urandom_range(1, 0)), "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int cnt;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(cmd_op == 3'd0, "R1", "cmd in reset", cmd_op, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(cmd_op == 3'd0, "R1", "cmd after reset", cmd_op, 0);
    mon_en = 1;

    // Closed, hit, second bank, return hit, conflict on one bank only.
    do_req(0, 0, 5, 3, 0, "R1");
    do_req(0, 0, 5, 9, 1, "R3");
    do_req(0, 1, 7, 1, 0, "R2");
    do_req(0, 0, 5, 4, 0, "R4");
    do_req(0, 1, 8, 2, 1, "R5");
    do_req(0, 0, 5, 6, 0, "R4");
    // Single-page select.
    do_req(2, 0, 1, 0, 0, "R2");
    do_req(2, 3, 1, 0, 1, "R6");
    do_req(2, 3, 1, 7, 0, "R3");
    do_req(2, 3, 2, 8, 0, "R6");
    // Fill every select, then revisit: ten rows stay open.
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 4; b++) do_req(s, b, 20 + s * 4 + b, b, 0, "");
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 4; b++) do_req(s, b, 20 + s * 4 + b, 200 + b, 1, "R10");
    do_req(2, 3, 31, 5, 0, "R10");
    do_req(3, 3, 35, 5, 0, "R10");
    cnt = 0;
    for (int s = 0; s < 4; s++) for (int b = 0; b < 4; b++) cnt += mvld[s][b];
    chk(cnt == 10, "R10", "model open rows", cnt, 10);

    set_timing(1, 1);
    rand_phase(150);
    set_timing(5, 4);
    rand_phase(100);
    set_timing(3, 2);
    rand_phase(60);
    repeat (12) @(negedge clk);
    finish_run();
  end

endmodule